// File: doc/BRIEF.md
# Restricted-ratio clock divider control

This block turns a fast system clock into a slower rate under register control. A 4-bit divisor code selects one of seven legal ratios: 1, 2, 3, 4, 6, 8 or 12. Codes that do not name a legal ratio are folded onto a neighbouring legal one. The block produces two outputs from the chosen ratio. The first is a one-cycle enable strobe, meant for logic that runs at the slow rate on the fast clock. The second is a divided square wave, meant to drive a downstream clock gating stage, which is not part of this block.

Software controls the divider through several pins:
- an active-low divider hold, which keeps the counter parked and also captures a new ratio;
- an enable, without which nothing comes out;
- a bypass, which passes the undivided source straight through.

A core reset forces the same hold as the divider hold. The ratio is taken from the code only while the divider is held. A code written while the divider runs waits until the next hold. The readback port always shows the ratio actually in use, after folding.

All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ratio_divider`

## Requirements
- R1: `ratio_rd` shows the folded ratio the divider is using, as a binary number. That number is always one of 1, 2, 3, 4, 6, 8 or 12, never the raw code.
- R2: Folding maps the code as follows. Codes 1, 2, 3, 4, 6, 8 and 12 keep their own value. Code 0 gives 1, code 5 gives 4 and code 7 gives 6. Codes 9, 10 and 11 give 8. Codes 13, 14 and 15 give 12.
- R3: While `cnt_clr_n` is 0, `tick` and `slow_out` are 0. When the hold is released, the divider restarts at phase 0, and the cycle of release counts as phase 0.
- R4: While `rst_n` is 0, the divider is held exactly as under R3, asynchronously. The code present at clock edges during core reset is captured as the ratio.
- R5: The ratio is loaded only at clock edges where the divider is held. A code change while the divider runs leaves `ratio_rd` and the output pattern unchanged until the next hold.
- R6: While `run_en` is 0, `tick` and `slow_out` are 0. Raising `run_en` again restarts the divider at phase 0.
- R7: While `pass_thru` is 1 and the divider is enabled and not held, `tick` is 1 on every cycle and `slow_out` equals `clk`. A ratio of 1 behaves the same way.
- R8: With ratio N ≥ 2, `tick` is high only at phase N-1. The phase counts up by one per clock edge, so `tick` is high once every N cycles.
- R9: With ratio N ≥ 2, `slow_out` is high for phases 0 to floor(N/2)-1 and low for the rest of the N phases. Even ratios therefore give a 50% duty cycle. Ratio 3 gives one cycle high and two cycles low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Core reset, active low, asynchronous; also holds the divider |
| div_code | input | 4 | Requested divisor code, folded per R2 |
| cnt_clr_n | input | 1 | Divider hold, active low; the ratio is captured while it is 0 |
| run_en | input | 1 | Output enable; both outputs are 0 while it is 0 |
| pass_thru | input | 1 | Bypass: the source passes undivided |
| tick | output | 1 | One-cycle strobe at the divided rate |
| slow_out | output | 1 | Divided square wave |
| ratio_rd | output | 4 | Effective ratio in use |

## Verification
The block has two pieces of internal state, the phase counter and the captured ratio. A wrong phase shows at once on the ports: `tick` fires in the wrong cycle, or the high part of `slow_out` starts at the wrong phase. The bench therefore compares both outputs cycle by cycle over three full periods after each release. A wrong captured ratio shows on `ratio_rd` one clock edge after the hold. It also shows within one period as a wrong spacing between `tick` pulses. Code changes made while the divider runs must leave both of these undisturbed.

// File: rtl/ratio_divider_pkg.sv
package ratio_divider_pkg;
  localparam int CODE_W  = 4;
  localparam int RATIO_W = 4;

  typedef logic [RATIO_W-1:0] ratio_t;

  // fold a requested code onto a legal ratio
  function automatic ratio_t fold_code(input logic [CODE_W-1:0] code);
    ratio_t r;
    case (code)
      4'd0:                 r = 4'd1;
      4'd5:                 r = 4'd4;
      4'd7:                 r = 4'd6;
      4'd9, 4'd10, 4'd11:   r = 4'd8;
      4'd13, 4'd14, 4'd15:  r = 4'd12;
      default:              r = ratio_t'(code);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ratio_fold.sv
module ratio_fold
  import ratio_divider_pkg::*;
#(
  parameter int CODE_W_P  = CODE_W,
  parameter int RATIO_W_P = RATIO_W
) (
  input  logic [CODE_W_P-1:0]  code_i,
  output logic [RATIO_W_P-1:0] ratio_o
);
  always_comb begin
    ratio_o = RATIO_W_P'(fold_code(CODE_W'(code_i)));
  end
endmodule

// File: rtl/ratio_latch.sv
module ratio_latch #(
  parameter int RATIO_W_P = 4
) (
  input  logic                 clk,
  input  logic                 load_i,
  input  logic [RATIO_W_P-1:0] ratio_i,
  output logic [RATIO_W_P-1:0] ratio_o
);
  // captured on every edge while held; no reset needed because the
  // core reset itself asserts load_i
  always_ff @(posedge clk) begin
    if (load_i) ratio_o <= ratio_i;
  end
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int RATIO_W_P = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv_i,
  input  logic [RATIO_W_P-1:0] ratio_i,
  output logic [RATIO_W_P-1:0] phase_o
);
  logic last;
  assign last = (phase_o == ratio_i - RATIO_W_P'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           phase_o <= '0;
    else if (!adv_i)      phase_o <= '0;
    else if (last)        phase_o <= '0;
    else                  phase_o <= phase_o + RATIO_W_P'(1);
  end
endmodule

// File: rtl/phase_decode.sv
module phase_decode #(
  parameter int RATIO_W_P = 4
) (
  input  logic                 clk,
  input  logic                 go_i,
  input  logic                 pass_i,
  input  logic [RATIO_W_P-1:0] ratio_i,
  input  logic [RATIO_W_P-1:0] phase_i,
  output logic                 tick_o,
  output logic                 slow_o
);
  logic [RATIO_W_P-1:0] half;
  logic                 at_end;
  logic                 hi_phase;

  always_comb begin
    half     = ratio_i >> 1;
    at_end   = (phase_i == ratio_i - RATIO_W_P'(1));
    hi_phase = (phase_i < half);
    tick_o   = go_i & (pass_i | at_end);
    slow_o   = go_i & (pass_i ? clk : hi_phase);
  end
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider
  import ratio_divider_pkg::*;
#(
  parameter int CODE_W_P  = CODE_W,
  parameter int RATIO_W_P = RATIO_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W_P-1:0]  div_code,
  input  logic                 cnt_clr_n,
  input  logic                 run_en,
  input  logic                 pass_thru,
  output logic                 tick,
  output logic                 slow_out,
  output logic [RATIO_W_P-1:0] ratio_rd
);
  localparam logic [RATIO_W_P-1:0] UNITY = RATIO_W_P'(1);

  logic [RATIO_W_P-1:0] folded;
  logic [RATIO_W_P-1:0] ratio_q;
  logic [RATIO_W_P-1:0] phase;
  logic                 hold;
  logic                 go;
  logic                 straight;
  logic                 adv;

  assign hold     = ~rst_n | ~cnt_clr_n;
  assign go       = ~hold & run_en;
  assign straight = pass_thru | (ratio_q == UNITY);
  assign adv      = cnt_clr_n & run_en & ~straight;

  ratio_fold #(.CODE_W_P(CODE_W_P), .RATIO_W_P(RATIO_W_P)) u_fold (
    .code_i  (div_code),
    .ratio_o (folded)
  );

  ratio_latch #(.RATIO_W_P(RATIO_W_P)) u_latch (
    .clk     (clk),
    .load_i  (hold),
    .ratio_i (folded),
    .ratio_o (ratio_q)
  );

  phase_counter #(.RATIO_W_P(RATIO_W_P)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv),
    .ratio_i (ratio_q),
    .phase_o (phase)
  );

  phase_decode #(.RATIO_W_P(RATIO_W_P)) u_decode (
    .clk     (clk),
    .go_i    (go),
    .pass_i  (straight),
    .ratio_i (ratio_q),
    .phase_i (phase),
    .tick_o  (tick),
    .slow_o  (slow_out)
  );

  assign ratio_rd = ratio_q;
endmodule

// File: rtl/ratio_divider_chk.sv
module ratio_divider_chk #(
  parameter int RATIO_W_P = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cnt_clr_n,
  input logic                 run_en,
  input logic                 pass_thru,
  input logic                 tick,
  input logic                 slow_out,
  input logic [RATIO_W_P-1:0] ratio_rd
);
  // R1: only legal ratios ever reach the readback
  a_r1_legal_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_rd == 1 || ratio_rd == 2 || ratio_rd == 3 || ratio_rd == 4 ||
     ratio_rd == 6 || ratio_rd == 8 || ratio_rd == 12));

  // R3: a held divider is silent
  a_r3_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr_n |-> (!tick && !slow_out));

  // R5: no ratio change across an edge where the divider ran
  a_r5_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_n |=> $stable(ratio_rd));

  // R6: disabled means silent
  a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (!tick && !slow_out));

  // R8: strobes never touch when dividing
  a_r8_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pass_thru && ratio_rd != 1) |=> (!tick || pass_thru));
endmodule

bind ratio_divider ratio_divider_chk #(.RATIO_W_P(RATIO_W_P)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_clr_n (cnt_clr_n),
  .run_en    (run_en),
  .pass_thru (pass_thru),
  .tick      (tick),
  .slow_out  (slow_out),
  .ratio_rd  (ratio_rd)
);

// File: tb/test_ratio_divider.sv
`timescale 1ns/1ps
module test_ratio_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_code = 4'd0;
  logic       cnt_clr_n = 1'b0;
  logic       run_en = 1'b0;
  logic       pass_thru = 1'b0;
  logic       tick;
  logic       slow_out;
  logic [3:0] ratio_rd;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ratio_divider i_ratio_divider (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .cnt_clr_n(cnt_clr_n),
    .run_en(run_en), .pass_thru(pass_thru), .tick(tick),
    .slow_out(slow_out), .ratio_rd(ratio_rd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_fold(input int c);
    case (c)
      0: return 1;
      5: return 4;
      7: return 6;
      9, 10, 11: return 8;
      13, 14, 15: return 12;
      default: return c;
    endcase
  endfunction

  // samples cycles phases starting at phase p0; caller is at negedge+1
  task automatic watch(input int n, input int cycles, input int p0,
                       output int bad_tick, output int bad_slow);
    bad_tick = 0;
    bad_slow = 0;
    for (int i = 0; i < cycles; i++) begin
      int ph;
      ph = (p0 + i) % n;
      if (tick !== ((n == 1) || (ph == n - 1))) bad_tick++;
      if (slow_out !== ((n >= 2) && (ph < n / 2))) bad_slow++;
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset;
    chk(tick === 1'b0, "R4 tick in core reset", tick, 0);
    chk(slow_out === 1'b0, "R4 slow_out in core reset", slow_out, 0);
  endtask

  task automatic t_fold_all;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cnt_clr_n = 1'b0;
      div_code = 4'(c);
      @(negedge clk); #1;
      chk(int'(ratio_rd) == ref_fold(c), "R2/R1 folded readback", ratio_rd, ref_fold(c));
    end
  endtask

  task automatic t_ratio(input int code);
    int n, bt, bs;
    n = ref_fold(code);
    @(negedge clk);
    cnt_clr_n = 1'b0; run_en = 1'b1; pass_thru = 1'b0; div_code = 4'(code);
    @(negedge clk); #1;
    chk(tick === 1'b0 && slow_out === 1'b0, "R3 held outputs", {tick, slow_out}, 0);
    @(negedge clk);
    cnt_clr_n = 1'b1;
    #1;
    watch(n, 3 * n + 2, 0, bt, bs);
    chk(bt == 0, "R8 tick pattern mismatches", bt, 0);
    chk(bs == 0, "R9 slow_out pattern mismatches", bs, 0);
  endtask

  task automatic t_unity_follows;
    @(negedge clk);
    cnt_clr_n = 1'b0; run_en = 1'b1; div_code = 4'd0;
    @(negedge clk);
    cnt_clr_n = 1'b1;
    @(posedge clk); #1;
    chk(slow_out === 1'b1 && tick === 1'b1, "R7 ratio 1 high phase", {tick, slow_out}, 3);
    @(negedge clk); #1;
    chk(slow_out === 1'b0 && tick === 1'b1, "R7 ratio 1 low phase", {tick, slow_out}, 2);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    cnt_clr_n = 1'b0; run_en = 1'b1; div_code = 4'd8;
    @(negedge clk);
    cnt_clr_n = 1'b1; pass_thru = 1'b1;
    @(posedge clk); #1;
    chk(slow_out === 1'b1 && tick === 1'b1, "R7 bypass high phase", {tick, slow_out}, 3);
    @(negedge clk); #1;
    chk(slow_out === 1'b0 && tick === 1'b1, "R7 bypass low phase", {tick, slow_out}, 2);
    chk(ratio_rd == 4'd8, "R1 bypass keeps ratio", ratio_rd, 8);
    pass_thru = 1'b0;
  endtask

  task automatic t_change_running;
    int bt, bs;
    @(negedge clk);
    cnt_clr_n = 1'b0; run_en = 1'b1; div_code = 4'd4;
    @(negedge clk);
    cnt_clr_n = 1'b1;
    #1;
    watch(4, 5, 0, bt, bs);   // now at phase 1
    div_code = 4'd9;
    #1;
    watch(4, 12, 1, bt, bs);
    chk(bt == 0 && bs == 0, "R5 pattern after running write", bt + bs, 0);
    chk(ratio_rd == 4'd4, "R5 readback after running write", ratio_rd, 4);
    cnt_clr_n = 1'b0;
    @(negedge clk); #1;
    chk(ratio_rd == 4'd8, "R5 write applied at hold", ratio_rd, 8);
  endtask

  task automatic t_enable_gap;
    int bt, bs, quiet;
    @(negedge clk);
    cnt_clr_n = 1'b0; run_en = 1'b1; div_code = 4'd6;
    @(negedge clk);
    cnt_clr_n = 1'b1;
    #1;
    watch(6, 4, 0, bt, bs);
    run_en = 1'b0;
    quiet = 0;
    for (int i = 0; i < 8; i++) begin
      #1;
      if (tick !== 1'b0 || slow_out !== 1'b0) quiet++;
      @(posedge clk); #1;
      if (tick !== 1'b0 || slow_out !== 1'b0) quiet++;
      @(negedge clk);
    end
    chk(quiet == 0, "R6 disabled outputs", quiet, 0);
    run_en = 1'b1;
    #1;
    watch(6, 14, 0, bt, bs);
    chk(bt == 0 && bs == 0, "R6 restart at phase 0", bt + bs, 0);
  endtask

  task automatic t_core_reset;
    int bt, bs;
    @(negedge clk);
    cnt_clr_n = 1'b0; run_en = 1'b1; div_code = 4'd2;
    @(negedge clk);
    cnt_clr_n = 1'b1;
    #1;
    watch(2, 3, 0, bt, bs);
    rst_n = 1'b0; div_code = 4'd14;
    #1;
    chk(tick === 1'b0 && slow_out === 1'b0, "R4 async hold", {tick, slow_out}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ratio_rd == 4'd12, "R4 code captured in reset", ratio_rd, 12);
    watch(12, 26, 0, bt, bs);
    chk(bt == 0 && bs == 0, "R4 restart after core reset", bt + bs, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_fold_all();
    t_ratio(2);
    t_ratio(3);
    t_ratio(4);
    t_ratio(6);
    t_ratio(8);
    t_ratio(12);
    t_ratio(11);
    t_ratio(0);
    t_unity_follows();
    t_bypass();
    t_change_running();
    t_enable_gap();
    t_core_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule